// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the four-state coherence state (Modified, Exclusive, Shared, Invalid) for a small, parameterised set of cache lines in a snooping shared-memory multiprocessor. It takes two request streams. One comes from the local processor: read, write or evict of a line. The other comes from bus commands that other caches place on the shared bus: bus read, bus write or bus upgrade. For each accepted request it decodes one fixed action from the current line state. That action can update the state, issue a bus transaction, assert a shared or dirty snoop response, request a writeback or flag a protocol error.

All action outputs are combinational and valid in the same cycle as the request. The new line state is registered at the next rising clock edge. The shared-line input is sampled in the cycle that a local read miss issues its bus read. If a local request and a snooped command name the same line in the same cycle, the snoop is served first. The local request is then refused through `loc_ready` and must be presented again. A lookup port returns the stored state of any line for the processor's tag path.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset, every line reads back as Invalid. The state code is I=00, S=01, E=10, M=11. The local op code is read=00, write=01, evict=10. The bus and snoop op code is read=00, write=01, upgrade=10.
- R2: A local read of an Invalid line issues a bus read (`bus_req_op`=00) in the same cycle. The line becomes Exclusive if `shared_in` is low in that cycle, and Shared if it is high.
- R3: A local write to an Invalid line issues a bus write (01). A local write to a Shared line issues a bus upgrade (10). In both cases the line becomes Modified.
- R4: A local write to an Exclusive line makes it Modified with no bus request. A local write to a Modified line, and a local read of an S, E or M line, cause no bus request and no state change.
- R5: An eviction makes any line Invalid. `evict_wb` is asserted only when the evicted line was Modified.
- R6: A snooped bus read asserts `snp_shared` in S (the line stays S) and in E (the line goes to S). In M it asserts `snp_dirty`, which supplies the data and writes it back, and the line goes to S.
- R7: A snooped bus write takes S and E to Invalid with no response. It takes M to Invalid with `snp_dirty` asserted.
- R8: A snooped bus upgrade takes S to Invalid. In E or M it asserts `proto_err` and leaves the state unchanged.
- R9: Any snooped command to an Invalid line gives no response, no error and no state change.
- R10: When a local request and a snoop name the same line in the same cycle, `loc_ready` is low and the local request has no effect, while the snoop is processed. Requests to different lines in the same cycle are both processed.
- R11: Op code 11 on either request stream has no effect on outputs or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| loc_vld | input | 1 | Local request valid |
| loc_op | input | 2 | Local op: 00 read, 01 write, 10 evict, 11 none |
| loc_idx | input | IDX_W | Line addressed by the local request |
| loc_ready | output | 1 | Low when the local request collides with a snoop on the same line |
| shared_in | input | 1 | Other caches hold the line; sampled during own bus read |
| bus_req_vld | output | 1 | Bus transaction requested |
| bus_req_op | output | 2 | Bus op: 00 read, 01 write, 10 upgrade |
| bus_req_idx | output | IDX_W | Line of the bus transaction |
| evict_wb | output | 1 | Write back a Modified line being evicted |
| evict_wb_idx | output | IDX_W | Line to write back on eviction |
| snp_vld | input | 1 | Snooped command valid |
| snp_op | input | 2 | Snooped op: 00 read, 01 write, 10 upgrade, 11 none |
| snp_idx | input | IDX_W | Line addressed by the snoop |
| snp_shared | output | 1 | Shared snoop response |
| snp_dirty | output | 1 | Dirty response: this cache supplies the data and writes it back |
| proto_err | output | 1 | Bus upgrade seen for a line held in E or M |
| look_idx | input | IDX_W | Line to read back |
| look_state | output | 2 | Stored state of line `look_idx` |

## Verification
The bench sweeps every line, every starting state and every op code on the local stream, with `shared_in` both low and high. This separates the miss path from the hit path and the Exclusive fill from the Shared fill. It then sweeps every line, state and snooped op. This separates the shared response, the dirty response, silent invalidation and the error case, and confirms that Invalid lines and op 11 stay inert. Paired same-line and different-line requests in one cycle show that a snoop takes precedence only on a collision, and that the refused local request succeeds once it is presented again.

// File: rtl/mesi_ctrl_pkg.sv
`timescale 1ns/1ps
package mesi_ctrl_pkg;
  typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11} line_st_t;
  typedef enum logic [1:0] {LOC_RD = 2'b00, LOC_WR = 2'b01, LOC_EV = 2'b10, LOC_NOP = 2'b11} loc_op_t;
  typedef enum logic [1:0] {BUS_RD = 2'b00, BUS_WR = 2'b01, BUS_UPG = 2'b10, BUS_NOP = 2'b11} bus_op_t;

  // decoded action for a local request
  typedef struct packed {
    logic     upd;
    line_st_t nxt;
    logic     bus_vld;
    bus_op_t  bus_op;
    logic     wb;
  } loc_act_t;

  // decoded action for a snooped command
  typedef struct packed {
    logic     upd;
    line_st_t nxt;
    logic     shr;
    logic     dty;
    logic     err;
  } snp_act_t;
endpackage

// File: rtl/mesi_local_fsm.sv
`timescale 1ns/1ps
module mesi_local_fsm
  import mesi_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_vld,
  input  loc_op_t  op,
  input  line_st_t cur,
  input  logic     shared_in,
  output loc_act_t act
);
  always_comb begin
    act     = '0;
    act.nxt = cur;
    if (req_vld) begin
      case (op)
        LOC_RD: begin
          if (cur == ST_I) begin
            act.upd     = 1'b1;
            act.bus_vld = 1'b1;
            act.bus_op  = BUS_RD;
            act.nxt     = shared_in ? ST_S : ST_E;
          end
        end
        LOC_WR: begin
          if (cur != ST_M) begin
            act.upd = 1'b1;
            act.nxt = ST_M;
          end
          if (cur == ST_I) begin
            act.bus_vld = 1'b1;
            act.bus_op  = BUS_WR;
          end else if (cur == ST_S) begin
            act.bus_vld = 1'b1;
            act.bus_op  = BUS_UPG;
          end
        end
        LOC_EV: begin
          if (cur != ST_I) begin
            act.upd = 1'b1;
            act.nxt = ST_I;
            act.wb  = (cur == ST_M);
          end
        end
        default: ;
      endcase
    end
  end

  // R5: writeback data can only come from a dirty line
  assert_wb_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act.wb |-> (cur == ST_M && op == LOC_EV));

  // R2, R3, R4: a bus request always leaves the line in a valid state
  assert_bus_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act.bus_vld |-> (act.upd && act.nxt != ST_I && cur inside {ST_I, ST_S}));
endmodule

// File: rtl/mesi_snoop_fsm.sv
`timescale 1ns/1ps
module mesi_snoop_fsm
  import mesi_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     snp_vld,
  input  bus_op_t  op,
  input  line_st_t cur,
  output snp_act_t act
);
  always_comb begin
    act     = '0;
    act.nxt = cur;
    if (snp_vld && cur != ST_I) begin
      case (op)
        BUS_RD: begin
          act.upd = (cur != ST_S);
          act.nxt = ST_S;
          act.shr = (cur != ST_M);
          act.dty = (cur == ST_M);
        end
        BUS_WR: begin
          act.upd = 1'b1;
          act.nxt = ST_I;
          act.dty = (cur == ST_M);
        end
        BUS_UPG: begin
          if (cur == ST_S) begin
            act.upd = 1'b1;
            act.nxt = ST_I;
          end else begin
            act.err = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R6, R7: a dirty response needs a Modified line
  assert_dirty_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act.dty |-> (cur == ST_M && !act.shr));

  // R9: an Invalid line never answers
  assert_inv_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_I) |-> !(act.shr || act.dty || act.err || act.upd));
endmodule

// File: rtl/mesi_state_array.sv
`timescale 1ns/1ps
module mesi_state_array
  import mesi_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  line_st_t         a_st,
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_idx,
  input  line_st_t         b_st,
  output line_st_t         st_q [NUM_LINES]
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_st_t d;
    logic     en;

    always_comb begin
      en = 1'b0;
      d  = st_q[g];
      if (a_we && a_idx == IDX_W'(g)) begin
        en = 1'b1;
        d  = a_st;
      end else if (b_we && b_idx == IDX_W'(g)) begin
        en = 1'b1;
        d  = b_st;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  st_q[g] <= ST_I;
      else if (en) st_q[g] <= d;
    end
  end

  // R10: the two write ports never name the same line together
  assert_port_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_we && b_we && a_idx == b_idx));
endmodule

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl
  import mesi_ctrl_pkg::*;
#(
  parameter  int NUM_LINES = 4,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loc_vld,
  input  logic [1:0]       loc_op,
  input  logic [IDX_W-1:0] loc_idx,
  output logic             loc_ready,
  input  logic             shared_in,
  output logic             bus_req_vld,
  output logic [1:0]       bus_req_op,
  output logic [IDX_W-1:0] bus_req_idx,
  output logic             evict_wb,
  output logic [IDX_W-1:0] evict_wb_idx,
  input  logic             snp_vld,
  input  logic [1:0]       snp_op,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             snp_shared,
  output logic             snp_dirty,
  output logic             proto_err,
  input  logic [IDX_W-1:0] look_idx,
  output logic [1:0]       look_state
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  line_st_t st_arr [NUM_LINES];
  line_st_t cur_loc, cur_snp;
  logic     collide, loc_go, snp_go;
  loc_act_t la;
  snp_act_t sa;

  assign collide   = loc_vld && snp_vld && (loc_idx == snp_idx);
  assign loc_ready = !collide;
  assign loc_go    = rst_int_n && loc_vld && !collide;
  assign snp_go    = rst_int_n && snp_vld;
  assign cur_loc   = st_arr[loc_idx];
  assign cur_snp   = st_arr[snp_idx];

  mesi_local_fsm u_loc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_vld   (loc_go),
    .op        (loc_op_t'(loc_op)),
    .cur       (cur_loc),
    .shared_in (shared_in),
    .act       (la)
  );

  mesi_snoop_fsm u_snp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .snp_vld (snp_go),
    .op      (bus_op_t'(snp_op)),
    .cur     (cur_snp),
    .act     (sa)
  );

  mesi_state_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_arr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .a_we  (sa.upd),
    .a_idx (snp_idx),
    .a_st  (sa.nxt),
    .b_we  (la.upd),
    .b_idx (loc_idx),
    .b_st  (la.nxt),
    .st_q  (st_arr)
  );

  assign bus_req_vld  = la.bus_vld;
  assign bus_req_op   = la.bus_op;
  assign bus_req_idx  = loc_idx;
  assign evict_wb     = la.wb;
  assign evict_wb_idx = loc_idx;
  assign snp_shared   = sa.shr;
  assign snp_dirty    = sa.dty;
  assign proto_err    = sa.err;
  assign look_state   = st_arr[look_idx];

  // R3, R4: an accepted local write always leaves the line Modified
  assert_wr_to_mod_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (loc_vld && loc_ready && loc_op == 2'b01) |=> (st_arr[$past(loc_idx)] == ST_M));

  // R2: a read miss fills as E or S according to the sampled shared line
  assert_fill_state_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (loc_vld && loc_ready && loc_op == 2'b00 && st_arr[loc_idx] == ST_I)
      |=> (st_arr[$past(loc_idx)] == ($past(shared_in) ? ST_S : ST_E)));

  // R10: a refused local request produces no local action
  assert_collide_quiet_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !loc_ready |-> !(bus_req_vld || evict_wb));

  // R8: the error flag is tied to a snooped upgrade
  assert_err_upg_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    proto_err |-> (snp_vld && snp_op == 2'b10 && $stable(st_arr[snp_idx])) or
                  (snp_vld && snp_op == 2'b10));
endmodule

// File: tb/mesi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       loc_vld, shared_in, snp_vld;
  logic [1:0] loc_op, snp_op;
  logic [1:0] loc_idx, snp_idx, look_idx;
  logic       loc_ready, bus_req_vld, evict_wb, snp_shared, snp_dirty, proto_err;
  logic [1:0] bus_req_op, bus_req_idx, evict_wb_idx, look_state;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mesi_line_ctrl #(.NUM_LINES(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .loc_vld(loc_vld), .loc_op(loc_op), .loc_idx(loc_idx), .loc_ready(loc_ready),
    .shared_in(shared_in),
    .bus_req_vld(bus_req_vld), .bus_req_op(bus_req_op), .bus_req_idx(bus_req_idx),
    .evict_wb(evict_wb), .evict_wb_idx(evict_wb_idx),
    .snp_vld(snp_vld), .snp_op(snp_op), .snp_idx(snp_idx),
    .snp_shared(snp_shared), .snp_dirty(snp_dirty), .proto_err(proto_err),
    .look_idx(look_idx), .look_state(look_state)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", "timeout", cyc, 100000);
      summary();
      $finish;
    end
  end

  task automatic peek(input logic [1:0] idx, input int exp, input string req, input string what);
    look_idx = idx;
    #1;
    chk(look_state == 2'(exp), req, what, look_state, exp);
  endtask

  task automatic pulse_loc(input logic [1:0] op, input logic [1:0] idx, input logic sh);
    @(negedge clk);
    loc_vld = 1'b1; loc_op = op; loc_idx = idx; shared_in = sh;
    @(posedge clk); #1;
    loc_vld = 1'b0;
  endtask

  // bring a line to state st (0=I,1=S,2=E,3=M) through local requests
  task automatic set_state(input logic [1:0] idx, input int st);
    pulse_loc(2'b10, idx, 1'b0);
    case (st)
      1: pulse_loc(2'b00, idx, 1'b1);
      2: pulse_loc(2'b00, idx, 1'b0);
      3: pulse_loc(2'b01, idx, 1'b0);
      default: ;
    endcase
  endtask

  initial begin
    rst_n = 1'b0; loc_vld = 1'b0; snp_vld = 1'b0; loc_op = 2'b00; snp_op = 2'b00;
    loc_idx = '0; snp_idx = '0; look_idx = '0; shared_in = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1: reset state
    for (int l = 0; l < 4; l++) peek(2'(l), 0, "R1", "reset state");
    chk(!bus_req_vld && !snp_shared && !snp_dirty && !proto_err && !evict_wb,
        "R1", "idle outputs", 0, 0);

    // local stream sweep
    for (int l = 0; l < 4; l++)
      for (int s0 = 0; s0 < 4; s0++)
        for (int op = 0; op < 4; op++)
          for (int sh = 0; sh < 2; sh++) begin
            int nxt, bo;
            bit bv, wb;
            string req;
            nxt = s0; bv = 0; bo = 0; wb = 0;
            case (op)
              0: begin req = (s0 == 0) ? "R2" : "R4";
                   if (s0 == 0) begin bv = 1; bo = 0; nxt = sh ? 1 : 2; end end
              1: begin req = (s0 >= 2) ? "R4" : "R3"; nxt = 3;
                   if (s0 == 0) begin bv = 1; bo = 1; end
                   else if (s0 == 1) begin bv = 1; bo = 2; end end
              2: begin req = "R5"; wb = (s0 == 3); nxt = 0; end
              default: req = "R11";
            endcase
            set_state(2'(l), s0);
            @(negedge clk);
            loc_vld = 1'b1; loc_op = 2'(op); loc_idx = 2'(l); shared_in = sh[0];
            #1;
            chk(loc_ready == 1'b1, req, "loc_ready", loc_ready, 1);
            chk(bus_req_vld == bv, req, "bus_req_vld", bus_req_vld, bv);
            if (bv) chk(bus_req_op == 2'(bo) && bus_req_idx == 2'(l), req, "bus_req_op",
                        bus_req_op, bo);
            chk(evict_wb == wb, req, "evict_wb", evict_wb, wb);
            if (wb) chk(evict_wb_idx == 2'(l), req, "evict_wb_idx", evict_wb_idx, l);
            @(posedge clk); #1;
            loc_vld = 1'b0;
            peek(2'(l), nxt, req, "local next state");
          end

    // snoop stream sweep
    for (int l = 0; l < 4; l++)
      for (int s0 = 0; s0 < 4; s0++)
        for (int op = 0; op < 4; op++) begin
          int nxt;
          bit es, ed, ee;
          string req;
          nxt = s0; es = 0; ed = 0; ee = 0;
          case (op)
            0: begin req = "R6";
                 if (s0 == 1) es = 1;
                 else if (s0 == 2) begin es = 1; nxt = 1; end
                 else if (s0 == 3) begin ed = 1; nxt = 1; end end
            1: begin req = "R7"; if (s0 != 0) nxt = 0; ed = (s0 == 3); end
            2: begin req = "R8"; if (s0 == 1) nxt = 0; else if (s0 >= 2) ee = 1; end
            default: req = "R11";
          endcase
          if (s0 == 0 && op != 3) req = "R9";
          set_state(2'(l), s0);
          @(negedge clk);
          snp_vld = 1'b1; snp_op = 2'(op); snp_idx = 2'(l);
          #1;
          chk(snp_shared == es, req, "snp_shared", snp_shared, es);
          chk(snp_dirty == ed, req, "snp_dirty", snp_dirty, ed);
          chk(proto_err == ee, req, "proto_err", proto_err, ee);
          @(posedge clk); #1;
          snp_vld = 1'b0;
          peek(2'(l), nxt, req, "snoop next state");
        end

    // R10: same-line collision, snoop wins and local retries
    set_state(2'd1, 1);
    set_state(2'd2, 2);
    @(negedge clk);
    loc_vld = 1'b1; loc_op = 2'b01; loc_idx = 2'd1;
    snp_vld = 1'b1; snp_op = 2'b01; snp_idx = 2'd1;
    #1;
    chk(loc_ready == 1'b0, "R10", "collide loc_ready", loc_ready, 0);
    chk(bus_req_vld == 1'b0, "R10", "collide bus_req_vld", bus_req_vld, 0);
    @(posedge clk); #1;
    snp_vld = 1'b0;
    peek(2'd1, 0, "R10", "snoop applied on collision");
    @(negedge clk);
    #1;
    chk(loc_ready && bus_req_vld && bus_req_op == 2'b01, "R10", "retry bus write",
        bus_req_op, 1);
    @(posedge clk); #1;
    loc_vld = 1'b0;
    peek(2'd1, 3, "R10", "retry result");

    // R10: different lines in one cycle both proceed
    set_state(2'd1, 1);
    @(negedge clk);
    loc_vld = 1'b1; loc_op = 2'b01; loc_idx = 2'd2;
    snp_vld = 1'b1; snp_op = 2'b00; snp_idx = 2'd1;
    #1;
    chk(loc_ready == 1'b1, "R10", "no collide loc_ready", loc_ready, 1);
    chk(bus_req_vld == 1'b0 && snp_shared == 1'b1, "R10", "parallel actions", snp_shared, 1);
    @(posedge clk); #1;
    loc_vld = 1'b0; snp_vld = 1'b0;
    peek(2'd2, 3, "R10", "local line after parallel");
    peek(2'd1, 1, "R10", "snooped line after parallel");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule